// File: doc/BRIEF.md
# Black-Level Offset Correction Controller

This block closes the digital side of a black-level loop in an image front end. Once per line, a filtered black-level average arrives together with a 10-bit target code and the 10-bit amplifier gain code. The controller turns the difference between them into two sign-magnitude offset DAC words, one coarse and one fine. The fine DAC moves the converted output by one output LSB per code and reaches ±255. The coarse DAC steps one code per update until the residue fits the fine range, and the fine DAC then takes up what is left.

The weight of one coarse code in output LSBs depends on the gain code. The block reports that weight as an integer multiplier so that the surrounding model or firmware can account for it. Either DAC can be taken out of the loop and driven from a register word. A start-order input selects which DAC the loop works on first. A status bit shows which DAC is currently being adjusted.

Top module: `obc_offset_ctrl`

## Requirements
- R1: After reset both DAC words are zero (sign 0, magnitude 0).
- R2: A loop update happens only on a clock edge where `upd_i` is 1 and the active-low strobe `cal_n_i` is 0. Otherwise both words hold their values.
- R3: The error is `avg_i - target_i`. When the fine DAC is being adjusted and the residue `fine - error` lies within ±255, the fine word becomes that residue.
- R4: When the residue lies outside ±255 during fine adjustment, the fine word saturates at +255 or -255. Adjustment then passes to the coarse DAC, provided the coarse DAC is in automatic mode.
- R5: During coarse adjustment, a residue outside ±255 steps the coarse value by exactly one code and leaves the fine word unchanged. The step is +1 when the residue is above +255 and -1 when it is below -255. A residue inside ±255 is written to the fine word, and adjustment passes to the fine DAC.
- R6: No magnitude exceeds 255 or wraps. When the coarse value is at ±255 and a further step would be needed in the same direction, the fine word takes the saturated residue instead.
- R7: `coarse_wt_o` is 4 for gain codes 0–63, 3 for 64–95, 2 for 96–127 and 1 for 128 and above.
- R8: With `coarse_byp_i`=1 and `fine_byp_i`=0, the coarse word follows `coarse_reg_i` one cycle later. The fine DAC stays in automatic mode and `fine_active_o` is 1.
- R9: With `fine_byp_i`=1, both words follow their register inputs one cycle later and updates have no effect. This holds whatever the value of `coarse_byp_i`.
- R10: On the first update after reset, or after coarse automatic mode has been re-entered, adjustment starts on the fine DAC when `fine_first_i`=1 and on the coarse DAC when it is 0.
- R11: On leaving bypass, the loop continues from the register values that were loaded, not from zero.
- R12: DAC words are {sign, magnitude[7:0]} with sign at bit 8 and 0 meaning positive. A zero value is always output with sign 0, including a register input of sign 1 and magnitude 0.
- R13: `fine_active_o` is 1 while the fine DAC is the one being adjusted and 0 while the coarse DAC is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line-processing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cal_n_i | input | 1 | Calibration strobe, active low |
| upd_i | input | 1 | One-cycle pulse: a new line average is valid |
| avg_i | input | 10 | Filtered black-level average |
| target_i | input | 10 | Target black code |
| gain_i | input | 10 | Amplifier gain code |
| coarse_byp_i | input | 1 | Coarse DAC taken from register |
| fine_byp_i | input | 1 | Fine DAC taken from register (disables both loops) |
| fine_first_i | input | 1 | Start adjustment with the fine DAC |
| coarse_reg_i | input | 9 | Register word for coarse DAC, {sign, magnitude} |
| fine_reg_i | input | 9 | Register word for fine DAC, {sign, magnitude} |
| coarse_o | output | 9 | Coarse DAC word, {sign, magnitude} |
| fine_o | output | 9 | Fine DAC word, {sign, magnitude} |
| fine_active_o | output | 1 | 1 while the fine DAC is being adjusted |
| coarse_wt_o | output | 3 | Output LSBs per coarse code multiplier |

## Verification
A wrong phase bit shows on `fine_active_o` at once. From the next update on, it also shows as a fine word that moves when the coarse word should step, or the reverse. A wrong saturation or sign conversion shows on the DAC words in the cycle after the update. Errors that build up over many lines are caught by a closed loop in the bench: a numeric plant feeds the outputs back as the next average, so a loop that fails to settle leaves a residual error at the end of the run.

// File: rtl/obc_pkg.sv
package obc_pkg;
  typedef enum logic {
    PH_COARSE = 1'b0,
    PH_FINE   = 1'b1
  } obc_phase_e;
endpackage

// File: rtl/obc_gain_weight.sv
module obc_gain_weight #(
  parameter int unsigned GW = 10,
  parameter int unsigned T1 = 64,
  parameter int unsigned T2 = 96,
  parameter int unsigned T3 = 128
) (
  input  logic [GW-1:0] gain_i,
  output logic [2:0]    wt_o
);
  always_comb begin
    if (gain_i < GW'(T1))      wt_o = 3'd4;
    else if (gain_i < GW'(T2)) wt_o = 3'd3;
    else if (gain_i < GW'(T3)) wt_o = 3'd2;
    else                       wt_o = 3'd1;
  end
endmodule

// File: rtl/obc_sm_reg.sv
module obc_sm_reg #(
  parameter int unsigned MW = 8,
  parameter int unsigned NW = MW + 2,
  localparam int unsigned VW = MW + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 byp_i,
  input  logic [MW:0]          reg_i,
  input  logic                 wr_i,
  input  logic signed [NW-1:0] nxt_i,
  output logic signed [VW-1:0] val_o,
  output logic [MW:0]          sm_o
);
  localparam logic signed [NW-1:0] HI = NW'(2**MW - 1);
  localparam logic signed [NW-1:0] LO = -HI;

  logic signed [VW-1:0] val_q, reg_val, nxt_sat, neg_v;

  always_comb begin
    reg_val = $signed({2'b00, reg_i[MW-1:0]});
    if (reg_i[MW]) reg_val = -reg_val;  // sign 1, mag 0 collapses to zero
  end

  always_comb begin
    if (nxt_i > HI)      nxt_sat = VW'(HI);
    else if (nxt_i < LO) nxt_sat = VW'(LO);
    else                 nxt_sat = VW'(nxt_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_q <= '0;
    else if (byp_i) val_q <= reg_val;
    else if (wr_i)  val_q <= nxt_sat;
  end

  assign neg_v = -val_q;
  assign val_o = val_q;
  assign sm_o  = (val_q < 0) ? {1'b1, neg_v[MW-1:0]} : {1'b0, val_q[MW-1:0]};

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byp_i && !wr_i) |=> $stable(sm_o)); // R2
endmodule

// File: rtl/obc_loop_ctrl.sv
module obc_loop_ctrl
  import obc_pkg::*;
#(
  parameter int unsigned MW = 8,
  parameter int unsigned DW = 10,
  localparam int unsigned VW = MW + 2,
  localparam int unsigned RW = ((DW > MW) ? DW : MW) + 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 upd_i,
  input  logic                 cal_n_i,
  input  logic [DW-1:0]        avg_i,
  input  logic [DW-1:0]        tgt_i,
  input  logic                 c_auto_i,
  input  logic                 f_auto_i,
  input  logic                 fine_first_i,
  input  logic signed [VW-1:0] c_val_i,
  input  logic signed [VW-1:0] f_val_i,
  output logic                 c_wr_o,
  output logic signed [VW-1:0] c_nxt_o,
  output logic                 f_wr_o,
  output logic signed [RW-1:0] f_nxt_o,
  output logic                 fine_act_o
);
  localparam logic signed [RW-1:0] LIM_P = RW'(2**MW - 1);
  localparam logic signed [VW-1:0] CMAX  = VW'(2**MW - 1);
  localparam logic signed [VW-1:0] ONE   = VW'(1);

  obc_phase_e phase_q, phase_d, phase_eff;
  logic armed_q;
  logic signed [RW-1:0] err, resid;
  logic fire, fits, c_up, c_lim;

  assign err   = $signed({{(RW-DW){1'b0}}, avg_i}) - $signed({{(RW-DW){1'b0}}, tgt_i});
  assign resid = RW'(f_val_i) - err;
  assign fits  = (resid <= LIM_P) && (resid >= -LIM_P);
  assign c_up  = resid > LIM_P;
  assign c_lim = c_up ? (c_val_i == CMAX) : (c_val_i == -CMAX);
  assign fire  = upd_i && !cal_n_i && f_auto_i;

  always_comb begin
    if (!c_auto_i)    phase_eff = PH_FINE;
    else if (armed_q) phase_eff = phase_q;
    else              phase_eff = obc_phase_e'(fine_first_i);
  end

  always_comb begin
    c_wr_o  = 1'b0;
    f_wr_o  = 1'b0;
    c_nxt_o = c_up ? c_val_i + ONE : c_val_i - ONE;
    f_nxt_o = resid;
    phase_d = phase_eff;
    if (fire) begin
      if (phase_eff == PH_COARSE) begin
        if (!fits && !c_lim) begin
          c_wr_o = 1'b1;
        end else begin
          f_wr_o  = 1'b1;
          phase_d = fits ? PH_FINE : PH_COARSE;
        end
      end else begin
        f_wr_o = 1'b1;
        if (!fits && c_auto_i) phase_d = PH_COARSE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_COARSE;
      armed_q <= 1'b0;
    end else if (!c_auto_i) begin
      phase_q <= PH_FINE;
      armed_q <= 1'b0;
    end else if (fire) begin
      phase_q <= phase_d;
      armed_q <= 1'b1;
    end
  end

  assign fine_act_o = (phase_eff == PH_FINE);

  AST_GATED_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_n_i || !upd_i) |-> !(c_wr_o || f_wr_o)); // R2
  AST_NO_LOOP_IN_FINE_BYP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !f_auto_i |-> !(c_wr_o || f_wr_o)); // R9
endmodule

// File: rtl/obc_offset_ctrl.sv
module obc_offset_ctrl
  import obc_pkg::*;
#(
  parameter int unsigned MW = 8,
  parameter int unsigned DW = 10,
  parameter int unsigned GW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cal_n_i,
  input  logic          upd_i,
  input  logic [DW-1:0] avg_i,
  input  logic [DW-1:0] target_i,
  input  logic [GW-1:0] gain_i,
  input  logic          coarse_byp_i,
  input  logic          fine_byp_i,
  input  logic          fine_first_i,
  input  logic [MW:0]   coarse_reg_i,
  input  logic [MW:0]   fine_reg_i,
  output logic [MW:0]   coarse_o,
  output logic [MW:0]   fine_o,
  output logic          fine_active_o,
  output logic [2:0]    coarse_wt_o
);
  localparam int unsigned VW = MW + 2;
  localparam int unsigned RW = ((DW > MW) ? DW : MW) + 3;

  logic c_auto, f_auto, c_wr, f_wr;
  logic signed [VW-1:0] c_val, f_val, c_nxt;
  logic signed [RW-1:0] f_nxt;

  assign f_auto = !fine_byp_i;
  assign c_auto = !coarse_byp_i && !fine_byp_i;

  obc_loop_ctrl #(.MW(MW), .DW(DW)) i_loop (
    .clk_i, .rst_ni, .upd_i, .cal_n_i,
    .avg_i, .tgt_i(target_i),
    .c_auto_i(c_auto), .f_auto_i(f_auto), .fine_first_i,
    .c_val_i(c_val), .f_val_i(f_val),
    .c_wr_o(c_wr), .c_nxt_o(c_nxt),
    .f_wr_o(f_wr), .f_nxt_o(f_nxt),
    .fine_act_o(fine_active_o)
  );

  obc_sm_reg #(.MW(MW), .NW(VW)) i_coarse (
    .clk_i, .rst_ni, .byp_i(!c_auto), .reg_i(coarse_reg_i),
    .wr_i(c_wr), .nxt_i(c_nxt), .val_o(c_val), .sm_o(coarse_o)
  );

  obc_sm_reg #(.MW(MW), .NW(RW)) i_fine (
    .clk_i, .rst_ni, .byp_i(!f_auto), .reg_i(fine_reg_i),
    .wr_i(f_wr), .nxt_i(f_nxt), .val_o(f_val), .sm_o(fine_o)
  );

  obc_gain_weight #(.GW(GW)) i_wt (.gain_i, .wt_o(coarse_wt_o));

  // assertion support: previous coarse value and mode
  logic signed [VW-1:0] c_prev_q;
  logic c_auto_q;
  logic signed [VW-1:0] c_dlt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_prev_q <= '0;
      c_auto_q <= 1'b0;
    end else begin
      c_prev_q <= c_val;
      c_auto_q <= c_auto;
    end
  end
  assign c_dlt = c_val - c_prev_q;

  AST_COARSE_ONE_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_auto && c_auto_q) |-> (c_dlt >= -VW'(1) && c_dlt <= VW'(1))); // R5
  AST_FINE_BYP_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fine_byp_i |=> (fine_o[MW-1:0] == $past(fine_reg_i[MW-1:0]))); // R9
  AST_BYP_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coarse_byp_i |-> fine_active_o); // R8
endmodule

// File: tb/test_obc_offset_ctrl.sv
`timescale 1ns/1ps
module test_obc_offset_ctrl;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cal_n_i = 1'b1, upd_i = 1'b0;
  logic [9:0] avg_i = '0, target_i = '0, gain_i = '0;
  logic coarse_byp_i = 1'b0, fine_byp_i = 1'b0, fine_first_i = 1'b0;
  logic [8:0] coarse_reg_i = '0, fine_reg_i = '0;
  logic [8:0] coarse_o, fine_o;
  logic fine_active_o;
  logic [2:0] coarse_wt_o;

  int checks = 0, errors = 0;
  bit running = 1'b0;
  int mc = 0, mf = 0, mph = 0, marmed = 0;

  always #10 clk_i = ~clk_i;

  obc_offset_ctrl i_obc_offset_ctrl (.*);

  function automatic int sm2i(logic [8:0] w);
    return w[8] ? -int'(w[7:0]) : int'(w[7:0]);
  endfunction
  function automatic logic [8:0] i2sm(int v);
    return (v < 0) ? {1'b1, 8'(-v)} : {1'b0, 8'(v)};
  endfunction
  function automatic int clamp255(int v);
    return (v > 255) ? 255 : (v < -255) ? -255 : v;
  endfunction
  function automatic int exp_wt(int g);
    return (g < 64) ? 4 : (g < 96) ? 3 : (g < 128) ? 2 : 1;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mc = 0; mf = 0; mph = 0; marmed = 0;
    end else begin
      int e, r, eff;
      bit ca, fire;
      ca   = !coarse_byp_i && !fine_byp_i;
      fire = upd_i && !cal_n_i && !fine_byp_i;
      eff  = !ca ? 1 : (marmed != 0 ? mph : int'(fine_first_i));
      e = int'(avg_i) - int'(target_i);
      r = mf - e;
      if (fine_byp_i) begin
        mc = sm2i(coarse_reg_i); mf = sm2i(fine_reg_i); marmed = 0;
      end else if (coarse_byp_i) begin
        mc = sm2i(coarse_reg_i); marmed = 0;
        if (fire) mf = clamp255(r);
      end else if (fire) begin
        marmed = 1;
        if (eff == 0) begin
          if ((r > 255 && mc < 255) || (r < -255 && mc > -255)) begin
            mc = mc + ((r > 0) ? 1 : -1); mph = 0;
          end else begin
            mf = clamp255(r); mph = (r >= -255 && r <= 255) ? 1 : 0;
          end
        end else begin
          mf = clamp255(r); mph = (r > 255 || r < -255) ? 0 : 1;
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (running && rst_ni) begin
      int es;
      es = (coarse_byp_i || fine_byp_i) ? 1 : (marmed != 0 ? mph : int'(fine_first_i));
      check("R5 coarse model", int'(coarse_o), int'(i2sm(mc)));
      check("R3 fine model", int'(fine_o), int'(i2sm(mf)));
      check("R13 status model", int'(fine_active_o), es);
      check("R7 weight model", int'(coarse_wt_o), exp_wt(int'(gain_i)));
    end
  end

  task automatic pulse(int a);
    @(negedge clk_i); avg_i = 10'(a); upd_i = 1'b1;
    @(negedge clk_i); upd_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    target_i = 10'd64; cal_n_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1; running = 1'b1;
    @(negedge clk_i);
    check("R1 coarse reset", int'(coarse_o), 0);
    check("R1 fine reset", int'(fine_o), 0);
    check("R10 start coarse", int'(fine_active_o), 0);

    pulse(100);
    check("R5 fits to fine", int'(fine_o), 9'h124);
    check("R13 now fine", int'(fine_active_o), 1);
    pulse(70);
    check("R3 fine residue", int'(fine_o), 9'h12A);
    pulse(400);
    check("R4 fine saturates", int'(fine_o), 9'h1FF);
    check("R4 pass to coarse", int'(fine_active_o), 0);
    pulse(400);
    check("R5 coarse step", int'(coarse_o), 9'h101);
    check("R5 fine held", int'(fine_o), 9'h1FF);
    cal_n_i = 1'b1;
    pulse(400);
    check("R2 strobe high ignored", int'(coarse_o), 9'h101);
    cal_n_i = 1'b0;
    pulse(64);
    check("R13 back to fine", int'(fine_active_o), 1);
    pulse(60);
    check("R3 fine absorbs", int'(fine_o), 9'h1FB);

    target_i = 10'd0;
    for (int i = 0; i < 300; i++) pulse(1023);
    check("R6 coarse saturated", int'(coarse_o), 9'h1FF);
    check("R6 fine saturated", int'(fine_o), 9'h1FF);

    gain_i = 10'd70;   #2 check("R7 gain 70", int'(coarse_wt_o), 3);
    gain_i = 10'd100;  #2 check("R7 gain 100", int'(coarse_wt_o), 2);
    gain_i = 10'd128;  #2 check("R7 gain 128", int'(coarse_wt_o), 1);
    gain_i = 10'd63;   #2 check("R7 gain 63", int'(coarse_wt_o), 4);
    gain_i = 10'd0;

    @(negedge clk_i);
    fine_byp_i = 1'b1; fine_reg_i = 9'h100; coarse_reg_i = 9'h003;
    repeat (2) @(negedge clk_i);
    check("R12 negative zero", int'(fine_o), 0);
    check("R9 coarse from reg", int'(coarse_o), 9'h003);
    pulse(500);
    check("R9 update ignored", int'(fine_o), 0);
    fine_reg_i = 9'h00A; fine_first_i = 1'b1;
    @(negedge clk_i);
    fine_byp_i = 1'b0;
    @(negedge clk_i);
    check("R10 start fine", int'(fine_active_o), 1);
    pulse(5);
    check("R11 resume from reg", int'(fine_o), 9'h005);
    check("R11 coarse kept", int'(coarse_o), 9'h003);

    coarse_byp_i = 1'b1; coarse_reg_i = 9'h105;
    @(negedge clk_i);
    check("R8 coarse follows reg", int'(coarse_o), 9'h105);
    check("R8 status fine", int'(fine_active_o), 1);
    pulse(3);
    check("R8 fine still auto", int'(fine_o), 9'h002);

    // closed loop against a numeric plant
    coarse_reg_i = 9'h003;
    @(negedge clk_i);
    coarse_byp_i = 1'b0; fine_first_i = 1'b0; target_i = 10'd64;
    for (int i = 0; i < 150; i++) begin
      int a;
      a = 700 + sm2i(fine_o) + int'(coarse_wt_o) * sm2i(coarse_o);
      a = (a < 0) ? 0 : (a > 1023) ? 1023 : a;
      pulse(a);
    end
    check("R5 loop settles", 700 + sm2i(fine_o) + 4 * sm2i(coarse_o), 64);

    running = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule